// File: doc/BRIEF.md
# Lockable configuration store

This block holds the configuration image of a small programmable logic fabric. The image has two parts. The first part is the AND-array connection bits. The second part is the output-cell control bits, which sit in the last words of the address space, after the array words. Each bit reads 1 when its connection is closed and 0 when it is open. A host drives one command per cycle and gets one response on the following cycle. The commands are erase-all, program word, read word and lock.

Programming can only close connections. Opening them again takes a full erase. The lock flag is sticky. While it is set, the host can neither read the image back nor change it. Only a completed full erase clears the lock, and that erase also wipes every word. The erase runs for a fixed number of cycles, and the block shows busy for that whole time.

Top module: `cfg_store_lock`

## Requirements
- R1: After reset, busy and locked are low, no response is valid, and every word reads as zero.
- R2: Each cycle with cmd_valid high produces exactly one response on the next cycle (resp_valid high). Cycles without a command produce no response.
- R3: Program (cmd_op=1) at a valid, unlocked address while not busy leaves the word equal to its old value OR cmd_wdata. No bit ever goes from 1 to 0 through programming.
- R4: Read (cmd_op=2) at a valid, unlocked address while not busy responds with resp_ok high and the stored word on resp_rdata.
- R5: Lock (cmd_op=3) while not busy is accepted and raises locked on the next cycle, even when already locked. Locked stays high until an erase completes.
- R6: While locked, read and program are refused (resp_ok low). Memory is left unchanged.
- R7: Erase (cmd_op=0) is accepted whenever not busy, including while locked. Busy is then high for exactly ERASE_CYCLES cycles, starting the cycle after acceptance. When busy falls, every word is zero and locked is low.
- R8: While busy, every command is refused and has no effect.
- R9: Read and program at an address at or beyond ARRAY_WORDS+MACRO_WORDS are refused and change nothing.
- R10: The cell-control words at addresses ARRAY_WORDS up to the last word are programmed and read exactly like array words.
- R11: Every response with resp_ok low, and every response that is not a read, carries resp_rdata equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 erase, 1 program, 2 read, 3 lock |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | WORD_W | Bits to close on program |
| resp_valid | output | 1 | Response for the previous cycle's command |
| resp_ok | output | 1 | Command accepted |
| resp_rdata | output | WORD_W | Read word, zero otherwise |
| busy | output | 1 | Erase in progress |
| locked | output | 1 | Lock flag |

## Verification
A corrupted word shows up on the next accepted read of that address, one cycle after the read is issued. A lock flag that is lost or stuck shows at once on the locked port. It also changes resp_ok on the very next read or program. An erase counter with the wrong length moves the falling edge of busy, and because the comparison runs every cycle, that is caught in the cycle where the edge should have occurred. A failure to clear memory at the end of an erase shows on the first read after busy falls.

// File: rtl/cfg_store_lock.sv
module cfg_store_lock #(
  parameter int WORD_W       = 16,
  parameter int ARRAY_WORDS  = 167,
  parameter int MACRO_WORDS  = 2,
  parameter int ERASE_CYCLES = 12,
  localparam int TOTAL_WORDS = ARRAY_WORDS + MACRO_WORDS,
  localparam int ADDR_W      = $clog2(TOTAL_WORDS),
  localparam int CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              resp_valid,
  output logic              resp_ok,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              busy,
  output logic              locked
);
  localparam logic [1:0] OP_ERASE = 2'd0;
  localparam logic [1:0] OP_PROG  = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_LOCK  = 2'd3;

  logic [WORD_W-1:0] mem [TOTAL_WORDS];
  logic [CNT_W-1:0]  cnt;
  logic              addr_ok, accept, wipe;

  assign busy    = cnt != '0;
  assign wipe    = cnt == CNT_W'(1);
  assign addr_ok = int'(cmd_addr) < TOTAL_WORDS;
  assign accept  = cmd_valid && !busy &&
                   (cmd_op == OP_ERASE || cmd_op == OP_LOCK || (!locked && addr_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (accept && cmd_op == OP_ERASE) begin
      cnt <= CNT_W'(ERASE_CYCLES);
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              locked <= 1'b0;
    else if (wipe)                           locked <= 1'b0;
    else if (accept && cmd_op == OP_LOCK)    locked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL_WORDS; i++) mem[i] <= '0;
    end else if (wipe) begin
      for (int i = 0; i < TOTAL_WORDS; i++) mem[i] <= '0;
    end else if (accept && cmd_op == OP_PROG) begin
      mem[cmd_addr] <= mem[cmd_addr] | cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= cmd_valid;
      resp_ok    <= accept;
      resp_rdata <= (accept && cmd_op == OP_READ) ? mem[cmd_addr] : '0;
    end
  end

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> resp_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !resp_valid);
  p_lock_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_LOCK) |=> locked);
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !wipe) |=> locked);
  p_lock_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && locked && (cmd_op == OP_PROG || cmd_op == OP_READ)) |=> !resp_ok);
  p_erase_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == OP_ERASE) |=> (busy && resp_ok));
  p_erase_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !locked);
  p_busy_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> !resp_ok);
  p_bad_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !addr_ok && (cmd_op == OP_PROG || cmd_op == OP_READ)) |=> !resp_ok);
  p_zero_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ok) |-> resp_rdata == '0);
endmodule

// File: tb/sim_cfg_store_lock.sv
module sim_cfg_store_lock;
  localparam int TOTAL = 169;
  localparam int ERASE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_addr = 8'd0;
  logic [15:0] cmd_wdata = 16'd0;
  logic resp_valid, resp_ok, busy, locked;
  logic [15:0] resp_rdata;

  int checks = 0;
  int errors = 0;

  logic [15:0] m [TOTAL];
  int cnt = 0;
  bit lk = 0;

  always #2 clk = ~clk;

  cfg_store_lock u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_rdata(resp_rdata), .busy(busy), .locked(locked)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input int a,
                      input logic [15:0] d, input string tag);
    bit acc;
    logic [15:0] e_rd;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a[7:0]; cmd_wdata = d;
    acc  = v && cnt == 0 && (op == 2'd0 || op == 2'd3 || (!lk && a < TOTAL));
    e_rd = 16'd0;
    if (acc && op == 2'd2) e_rd = m[a];
    if (cnt != 0) begin
      cnt--;
      if (cnt == 0) begin
        for (int i = 0; i < TOTAL; i++) m[i] = 16'd0;
        lk = 0;
      end
    end
    if (acc) begin
      case (op)
        2'd0: cnt = ERASE;
        2'd1: m[a] = m[a] | d;
        2'd3: lk = 1;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk(tag, "resp_valid", int'(resp_valid), int'(v));
    chk(tag, "resp_ok", int'(resp_ok), int'(acc));
    chk(tag, "resp_rdata", int'(resp_rdata), int'(e_rd));
    chk(tag, "busy", int'(busy), int'(cnt != 0));
    chk(tag, "locked", int'(locked), int'(lk));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 2'd0, 0, 16'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < TOTAL; i++) m[i] = 16'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "locked", int'(locked), 0);
    chk("R1", "resp_valid", int'(resp_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    idle("R1");
    for (int a = 0; a < TOTAL; a += 21) step(1'b1, 2'd2, a, 16'd0, "R1");
    step(1'b1, 2'd2, TOTAL - 1, 16'd0, "R1");

    step(1'b1, 2'd1, 5, 16'hA5A5, "R3");
    step(1'b1, 2'd2, 5, 16'd0, "R4");
    step(1'b1, 2'd1, 5, 16'h0F0F, "R3");
    step(1'b1, 2'd2, 5, 16'd0, "R3");
    step(1'b1, 2'd1, 5, 16'h0000, "R3");
    step(1'b1, 2'd2, 5, 16'd0, "R4");
    idle("R2");
    step(1'b1, 2'd1, 166, 16'h8001, "R4");
    step(1'b1, 2'd2, 166, 16'd0, "R4");

    step(1'b1, 2'd1, 167, 16'h1234, "R10");
    step(1'b1, 2'd1, 168, 16'hC3C3, "R10");
    step(1'b1, 2'd2, 167, 16'd0, "R10");
    step(1'b1, 2'd2, 168, 16'd0, "R10");

    step(1'b1, 2'd1, 200, 16'hFFFF, "R9");
    step(1'b1, 2'd2, 200, 16'd0, "R9");
    step(1'b1, 2'd2, 255, 16'd0, "R9");
    step(1'b1, 2'd2, 168, 16'd0, "R9");

    step(1'b1, 2'd3, 0, 16'd0, "R5");
    idle("R5");
    step(1'b1, 2'd2, 5, 16'd0, "R6");
    step(1'b1, 2'd1, 5, 16'hFFFF, "R6");
    step(1'b1, 2'd1, 9, 16'hFFFF, "R6");
    step(1'b1, 2'd3, 0, 16'd0, "R5");
    step(1'b1, 2'd2, 168, 16'd0, "R11");

    step(1'b1, 2'd0, 0, 16'd0, "R7");
    step(1'b1, 2'd2, 5, 16'd0, "R8");
    step(1'b1, 2'd0, 0, 16'd0, "R8");
    step(1'b1, 2'd3, 0, 16'd0, "R8");
    step(1'b1, 2'd1, 7, 16'h00FF, "R8");
    for (int k = 0; k < ERASE; k++) idle("R7");
    step(1'b1, 2'd2, 5, 16'd0, "R7");
    step(1'b1, 2'd2, 168, 16'd0, "R7");
    step(1'b1, 2'd2, 7, 16'd0, "R8");
    step(1'b1, 2'd1, 5, 16'h0003, "R7");
    step(1'b1, 2'd2, 5, 16'd0, "R7");
    step(1'b1, 2'd0, 0, 16'd0, "R7");
    for (int k = 0; k < ERASE + 1; k++) idle("R7");

    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      logic [1:0] op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = (lfsr[3:0] == 4'd0) ? 2'd0 : (lfsr[3:0] == 4'd1) ? 2'd3 : lfsr[4] ? 2'd1 : 2'd2;
      step(lfsr[5] | lfsr[6], op, int'(lfsr[15:8]) % 176, {lfsr[7:0], lfsr[15:8]}, "R11");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule